// File: doc/BRIEF.md
# Trace Buffer Byte Readout

The block keeps the last eight 16-bit words of a debug trace in a shift chain and lets a host read them through two byte-wide ports. The host reads the high byte first and the low byte second to get one coherent word. The low-byte read also advances the chain, so the next word reaches the ports. In byte-capture mode only the low port carries data. Each low-byte read returns one 8-bit value and advances the chain.

While the debugger is armed, the block stores each word offered on the capture strobe. Trigger decisions and classification of the captured words happen upstream. While the debugger is disarmed, the block works as a sampling profiler: every low-byte read pushes the current opcode-fetch address into the chain. The first eight values read out in this mode are stale fill, and the host discards them. A saturating count tells the host how many words were captured since the last arming, so it knows how many leading reads are dummies.

Top module: `trace_fifo_readout`

## Requirements
- R1: While reset is asserted, `count_o`, `hi_data_o` and `lo_data_o` are all zero.
- R2: New words enter at the far end of an eight-stage chain, and the ports show the near end. After c captures since arming (c ≤ 8) and no reads, 8 − c low reads bring the oldest captured word to the ports.
- R3: In word mode, a low read returns the low byte at the ports and shifts the chain by one stage. From the next cycle the following word is at both ports.
- R4: In word mode, a high read latches the whole word at the ports. Until the next low read, both ports hold that word, even if captures shift the chain in between. The low read then clears the latch.
- R5: In byte mode, `hi_data_o` is zero and a high read has no effect. A capture stores only bits [7:0], with the upper byte zero. The low port always shows the near end of the chain.
- R6: When the chain already holds eight captured words, a further capture discards the oldest word.
- R7: Each capture while armed raises `count_o` by one, and `count_o` saturates at 8.
- R8: In the cycle after `arm_i` rises, `count_o` is 0, or 1 if a capture arrived in the rising cycle. Any latched high-read word is dropped.
- R9: While `arm_i` is 0, a low read inserts `fetch_addr_i` at the far end and raises `count_o` by one, saturating at 8. `cap_en_i` is ignored.
- R10: While armed, a low read without a capture inserts zero at the far end.
- R11: A capture and a low read in the same armed cycle cause one shift. The read returns the old near-end word and the captured word enters the far end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Debugger armed; its rising edge clears the count |
| byte_mode_i | input | 1 | 1 selects 8-bit capture and readout |
| cap_en_i | input | 1 | Capture strobe, honoured only while armed |
| cap_data_i | input | 16 | Word to capture |
| fetch_addr_i | input | 16 | Address of the most recently fetched opcode |
| rd_hi_i | input | 1 | Host read of the high-byte port |
| rd_lo_i | input | 1 | Host read of the low-byte port; advances the chain |
| hi_data_o | output | 8 | High-byte read port |
| lo_data_o | output | 8 | Low-byte read port |
| count_o | output | 4 | Words captured since arming, saturating at 8 |

## Verification
Both ports and the count are driven straight from registers, so in the cycle a read strobe is given they still show the state from before the strobe. The effect of every strobe (shift, latch, insert, count step or clear) appears one edge later. The bench drives strobes on the falling edge. It compares every port against a queue-based model 1 ns later, before the rising edge that acts on the strobe. It makes its targeted checks 2 ns after that rising edge, while the inputs can no longer act.

// File: rtl/trace_fifo_pkg.sv
package trace_fifo_pkg;
  typedef enum logic [1:0] {
    TAIL_ZERO    = 2'd0,
    TAIL_CAPTURE = 2'd1,
    TAIL_FETCH   = 2'd2
  } tail_sel_e;
endpackage

// File: rtl/trace_shift_store.sv
module trace_shift_store #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic [WORD_W-1:0] tail_i,
  output logic [WORD_W-1:0] head_o
);
  logic [DEPTH-1:0][WORD_W-1:0] stage_q;
  logic [DEPTH-1:0][WORD_W-1:0] stage_d;

  // stage 0 faces the read ports, stage DEPTH-1 takes new words
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == DEPTH - 1) begin : g_tail
      assign stage_d[g] = tail_i;
    end else begin : g_body
      assign stage_d[g] = stage_q[g+1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stage_q <= '0;
    else if (shift_i) stage_q <= stage_d;
  end

  assign head_o = stage_q[0];
endmodule

// File: rtl/trace_fill_count.sv
module trace_fill_count #(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CntMax = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CntOne = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clear_i)                 cnt_q <= inc_i ? CntOne : '0;
    else if (inc_i && cnt_q != CntMax) cnt_q <= cnt_q + CntOne;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/trace_read_port.sv
module trace_read_port #(
  parameter int WORD_W = 16,
  parameter int BYTE_W = WORD_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              byte_mode_i,
  input  logic              rd_hi_i,
  input  logic              rd_lo_i,
  input  logic [WORD_W-1:0] head_i,
  output logic [BYTE_W-1:0] hi_o,
  output logic [BYTE_W-1:0] lo_o,
  output logic              hold_vld_o
);
  logic [WORD_W-1:0] hold_q;
  logic              hold_vld_q;

  // low read consumes the latch; high read only latches in word mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
    end else if (clear_i || rd_lo_i) begin
      hold_vld_q <= 1'b0;
    end else if (rd_hi_i && !byte_mode_i) begin
      hold_q     <= head_i;
      hold_vld_q <= 1'b1;
    end
  end

  logic use_hold;
  assign use_hold = hold_vld_q && !byte_mode_i;

  always_comb begin
    lo_o = use_hold ? hold_q[BYTE_W-1:0] : head_i[BYTE_W-1:0];
    if (byte_mode_i) hi_o = '0;
    else             hi_o = use_hold ? hold_q[WORD_W-1:BYTE_W] : head_i[WORD_W-1:BYTE_W];
  end

  assign hold_vld_o = hold_vld_q;
endmodule

// File: rtl/trace_fifo_readout.sv
module trace_fifo_readout
  import trace_fifo_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 16,
  parameter int BYTE_W = WORD_W / 2,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              byte_mode_i,
  input  logic              cap_en_i,
  input  logic [WORD_W-1:0] cap_data_i,
  input  logic [WORD_W-1:0] fetch_addr_i,
  input  logic              rd_hi_i,
  input  logic              rd_lo_i,
  output logic [BYTE_W-1:0] hi_data_o,
  output logic [BYTE_W-1:0] lo_data_o,
  output logic [CNT_W-1:0]  count_o
);
  logic              arm_q;
  logic              arm_rise;
  logic              cap_take;
  logic              shift;
  logic              cnt_inc;
  tail_sel_e         tail_sel;
  logic [WORD_W-1:0] cap_word;
  logic [WORD_W-1:0] tail_word;
  logic [WORD_W-1:0] head_word;
  logic              hold_vld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_q <= 1'b0;
    else         arm_q <= arm_i;
  end

  assign arm_rise = arm_i && !arm_q;
  assign cap_take = arm_i && cap_en_i;
  assign shift    = cap_take || rd_lo_i;
  // profiling: a disarmed read is itself a capture of the fetch address
  assign cnt_inc  = cap_take || (!arm_i && rd_lo_i);

  assign cap_word = byte_mode_i ? {{(WORD_W-BYTE_W){1'b0}}, cap_data_i[BYTE_W-1:0]} : cap_data_i;

  always_comb begin
    if (cap_take)   tail_sel = TAIL_CAPTURE;
    else if (arm_i) tail_sel = TAIL_ZERO;
    else            tail_sel = TAIL_FETCH;
    case (tail_sel)
      TAIL_CAPTURE: tail_word = cap_word;
      TAIL_FETCH:   tail_word = fetch_addr_i;
      default:      tail_word = '0;
    endcase
  end

  trace_shift_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift),
    .tail_i  (tail_word),
    .head_o  (head_word)
  );

  trace_fill_count #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (arm_rise),
    .inc_i   (cnt_inc),
    .count_o (count_o)
  );

  trace_read_port #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) i_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (arm_rise),
    .byte_mode_i (byte_mode_i),
    .rd_hi_i     (rd_hi_i),
    .rd_lo_i     (rd_lo_i),
    .head_i      (head_word),
    .hi_o        (hi_data_o),
    .lo_o        (lo_data_o),
    .hold_vld_o  (hold_vld)
  );
endmodule

// File: rtl/trace_fifo_readout_chk.sv
module trace_fifo_readout_chk #(
  parameter int DEPTH  = 8,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              arm_i,
  input logic              arm_q,
  input logic              byte_mode_i,
  input logic              cap_en_i,
  input logic              rd_hi_i,
  input logic              rd_lo_i,
  input logic              hold_vld,
  input logic [BYTE_W-1:0] hi_data_o,
  input logic [BYTE_W-1:0] lo_data_o,
  input logic [CNT_W-1:0]  count_o
);
  localparam logic [CNT_W-1:0] CntMax = CNT_W'(DEPTH);

  assert_count_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CntMax);

  assert_count_sat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && arm_q && cap_en_i && count_o == CntMax) |=> count_o == CntMax);

  assert_arm_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !arm_q && !cap_en_i) |=> count_o == '0);

  assert_profile_inc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arm_i && rd_lo_i && count_o != CntMax) |=> count_o == $past(count_o) + CNT_W'(1));

  assert_lo_consumes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lo_i |=> !hold_vld);

  assert_hi_latches_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hi_i && !rd_lo_i && !byte_mode_i && !(arm_i && !arm_q)) |=> hold_vld);

  assert_hold_steady_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_vld && !rd_lo_i && !rd_hi_i && !byte_mode_i && !(arm_i && !arm_q))
      |=> (byte_mode_i || ($stable(hi_data_o) && $stable(lo_data_o))));

  assert_byte_hi_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_mode_i |-> hi_data_o == '0);
endmodule

bind trace_fifo_readout trace_fifo_readout_chk #(
  .DEPTH (DEPTH),
  .BYTE_W(BYTE_W),
  .CNT_W (CNT_W)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .arm_i       (arm_i),
  .arm_q       (arm_q),
  .byte_mode_i (byte_mode_i),
  .cap_en_i    (cap_en_i),
  .rd_hi_i     (rd_hi_i),
  .rd_lo_i     (rd_lo_i),
  .hold_vld    (hold_vld),
  .hi_data_o   (hi_data_o),
  .lo_data_o   (lo_data_o),
  .count_o     (count_o)
);

// File: tb/test_trace_fifo_readout.sv
module test_trace_fifo_readout;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        arm_i, byte_mode_i, cap_en_i, rd_hi_i, rd_lo_i;
  logic [15:0] cap_data_i, fetch_addr_i;
  logic [7:0]  hi_data_o, lo_data_o;
  logic [3:0]  count_o;

  always #10 clk_i = ~clk_i;

  trace_fifo_readout i_trace_fifo_readout (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int mq[$];
  int mcnt, mhold;
  bit mhold_v, marm_prev;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit a, bit b, bit c, int d, int f, bit h, bit l);
    int eh, el, tail, hb, base;
    bit rise, ce, inc;
    @(negedge clk_i);
    arm_i = a; byte_mode_i = b; cap_en_i = c; cap_data_i = d[15:0];
    fetch_addr_i = f[15:0]; rd_hi_i = h; rd_lo_i = l;
    #1;
    eh = b ? 0 : (mhold_v ? (mhold >> 8) & 'hff : (mq[0] >> 8) & 'hff);
    el = (!b && mhold_v) ? mhold & 'hff : mq[0] & 'hff;
    chk(b ? "R5 model hi" : "R3 model hi", int'(hi_data_o), eh);
    chk(b ? "R5 model lo" : "R3 model lo", int'(lo_data_o), el);
    chk("R7 model count", int'(count_o), mcnt);
    @(posedge clk_i);
    rise = a && !marm_prev;
    ce   = a && c;
    tail = ce ? (b ? d & 'hff : d & 'hffff) : (a ? 0 : f & 'hffff);
    hb   = mq[0];
    if (ce || l) begin
      void'(mq.pop_front());
      mq.push_back(tail);
    end
    inc  = ce || (!a && l);
    base = rise ? 0 : mcnt;
    mcnt = inc ? ((base < 8) ? base + 1 : 8) : base;
    if (rise || l) mhold_v = 1'b0;
    else if (h && !b) begin mhold = hb; mhold_v = 1'b1; end
    marm_prev = a;
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    arm_i = 0; byte_mode_i = 0; cap_en_i = 0; rd_hi_i = 0; rd_lo_i = 0;
    cap_data_i = 0; fetch_addr_i = 0;
    for (int i = 0; i < 8; i++) mq.push_back(0);
    mcnt = 0; mhold = 0; mhold_v = 0; marm_prev = 0;
    rst_ni = 1'b1;
    #1 rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    #3;
    chk("R1 reset count", int'(count_o), 0);
    chk("R1 reset hi", int'(hi_data_o), 0);
    chk("R1 reset lo", int'(lo_data_o), 0);
    @(negedge clk_i) rst_ni = 1'b1;

    // R2: three captures, then 8-3 reads reach the oldest
    cyc(1, 0, 1, 'hA1B2, 0, 0, 0);
    cyc(1, 0, 1, 'hC3D4, 0, 0, 0);
    cyc(1, 0, 1, 'hE5F6, 0, 0, 0);
    settle();
    chk("R7 count after three", int'(count_o), 3);
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 0, 0, 1);
    settle();
    chk("R2 oldest hi", int'(hi_data_o), 'hA1);
    chk("R2 oldest lo", int'(lo_data_o), 'hB2);

    // R4: latch survives an intervening capture
    cyc(1, 0, 0, 0, 0, 1, 0);
    cyc(1, 0, 1, 'h1357, 0, 0, 0);
    settle();
    chk("R4 held hi", int'(hi_data_o), 'hA1);
    chk("R4 held lo", int'(lo_data_o), 'hB2);
    cyc(1, 0, 0, 0, 0, 0, 1);
    settle();
    chk("R3 next hi", int'(hi_data_o), 'hE5);
    chk("R3 next lo", int'(lo_data_o), 'hF6);

    // R8: re-arm clears the count
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    settle();
    chk("R8 count cleared", int'(count_o), 0);

    // R6, R7: nine captures overflow
    for (int k = 0; k < 9; k++) cyc(1, 0, 1, 'h1000 + k, 0, 0, 0);
    settle();
    chk("R7 count saturated", int'(count_o), 8);
    chk("R6 oldest dropped hi", int'(hi_data_o), 'h10);
    chk("R6 oldest dropped lo", int'(lo_data_o), 'h01);

    // R11: capture and read together
    cyc(1, 0, 1, 'h2222, 0, 0, 1);
    settle();
    chk("R11 single shift lo", int'(lo_data_o), 'h02);
    for (int i = 0; i < 7; i++) cyc(1, 0, 0, 0, 0, 0, 1);
    settle();
    chk("R11 tail word hi", int'(hi_data_o), 'h22);
    // R10: armed reads fill with zero
    cyc(1, 0, 0, 0, 0, 0, 1);
    settle();
    chk("R10 zero fill hi", int'(hi_data_o), 0);
    chk("R10 zero fill lo", int'(lo_data_o), 0);

    // R5: byte mode
    cyc(0, 0, 0, 0, 0, 0, 0);
    cyc(1, 1, 1, 'h12AB, 0, 0, 0);
    cyc(1, 1, 1, 'h34CD, 0, 0, 0);
    for (int i = 0; i < 6; i++) cyc(1, 1, 0, 0, 0, 0, 1);
    settle();
    chk("R5 byte lo", int'(lo_data_o), 'hAB);
    chk("R5 byte hi zero", int'(hi_data_o), 0);
    cyc(1, 1, 0, 0, 0, 1, 0);
    cyc(1, 1, 1, 'h5678, 0, 0, 0);
    settle();
    chk("R5 high read ignored", int'(lo_data_o), 'hCD);

    // R9: disarmed profiling
    cyc(0, 0, 0, 0, 'hF000, 0, 1);
    settle();
    chk("R9 profile count step", int'(count_o), 4);
    for (int k = 1; k < 8; k++) cyc(0, 0, 0, 0, 'hF000 + k, 0, 1);
    settle();
    chk("R9 profile count sat", int'(count_o), 8);
    chk("R9 fetch addr hi", int'(hi_data_o), 'hF0);
    chk("R9 fetch addr lo", int'(lo_data_o), 'h00);
    cyc(0, 0, 1, 'h9999, 0, 0, 0);
    settle();
    chk("R9 capture ignored lo", int'(lo_data_o), 'h00);
    chk("R9 capture ignored count", int'(count_o), 8);
    cyc(0, 0, 0, 0, 'hF008, 0, 1);
    settle();
    chk("R9 next fetch lo", int'(lo_data_o), 'h01);
    cyc(0, 0, 0, 0, 0, 0, 0);

    finish_run();
  end
endmodule